// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable behavioural model of a pipelined synchronous SRAM whose bus can change direction on any cycle without an idle slot. On each enabled rising edge it takes either a new command or a burst step. A new command is a read, a write, or a deselect. A burst step moves a 2-bit counter on the two low address bits, in linear or interleaved order. Data for a command uses the same cycle of the bus whether the command is a read or a write. Read data is in the output register in the cycle that ends at the second enabled edge after the load. Write data is sampled at that same second edge. Because of this, reads and writes can alternate freely.

A two-entry operation pipeline holds each command's address and byte-lane selects until its data window. When a read's address matches the write whose data is being sampled in the same cycle, the array still holds the old value. The read therefore takes each enabled byte lane from the write-data input and the remaining lanes from the array. The controller drives separate input data, output data and output-enable signals; no tristate pin is modelled.

The command sequencer is a three-state machine: ST_IDLE (no operation in flight), ST_READ and ST_WRITE. Its transitions on an enabled edge are as follows:
- LOAD_DESEL: a load while deselected goes to ST_IDLE.
- LOAD_RD: a selected load with `wr_n` high goes to ST_READ.
- LOAD_WR: a selected load with `wr_n` low goes to ST_WRITE.
- ADVANCE: a burst step stays in the current state, and in ST_READ or ST_WRITE it steps the burst counter.

Top module: `zt_sram`

## Requirements
- R1: After reset, `rdata_oe` is 0 and `rdata` is 0.
- R2: A selected read loaded at enabled edge E0 puts the addressed word on `rdata` with `rdata_oe`=1 after enabled edge E1, until the next enabled edge.
- R3: A selected write loaded at E0 takes `wdata` at E2; lane i (bits 9i+8..9i) is written only when `lane_wr_n[i]`=0, and the other lanes keep their contents.
- R4: A load is selected only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. A deselected load starts nothing: `rdata_oe` stays 0 in its data window, and no word is written even when `wr_n`=0.
- R5: Reads and writes may alternate on every enabled cycle with no idle cycle, and every read returns the value left by all earlier commands.
- R6: Throughout the cycle in which write data is sampled, `rdata_oe` is 0.
- R7: An edge with `en_n`=1 changes nothing: the pipeline, the burst counter, `rdata` and `rdata_oe` all hold.
- R8: With `interleave`=0 at the load, burst beat k uses low address bits (base+k) mod 4, and the upper address bits stay fixed. An `advance`=1 edge takes the next beat, a fifth beat wraps back to the base, and each beat uses the `lane_wr_n` present at its own edge.
- R9: With `interleave`=1 at the load, burst beat k uses low address bits base XOR k.
- R10: A read loaded one edge after a write to the same address returns the write's enabled lanes merged over the older contents.
- R11: On an `advance`=1 edge, `cs_a_n`, `cs_b`, `cs_c_n`, `wr_n`, `interleave` and `addr` are ignored. A burst step after a deselected load is again no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_n | input | 1 | Clock enable, active low |
| cs_a_n | input | 1 | Chip select A, active low |
| cs_b | input | 1 | Chip select B, active high |
| cs_c_n | input | 1 | Chip select C, active low |
| advance | input | 1 | 1 = burst step, 0 = load new command |
| wr_n | input | 1 | 0 = write, 1 = read, at a load |
| lane_wr_n | input | LANES | Per-lane write select, active low |
| interleave | input | 1 | Burst order at a load: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, sampled in the write's data window |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_oe | output | 1 | Output-drive enable for rdata |

## Verification
The properties assume that every control input is at a defined level on each edge after reset. They also assume that a controller only issues a burst step after some load, so the state machine's notion of "current operation" is meaningful. The stimulus drives every input with a defined value on every cycle, including held cycles, where it drives random values to show that they are ignored. Random control values are drawn only from the legal encodings. Bursts and deselects are mixed into the random traffic, so that the hold, contention and burst-address properties are exercised across all three states.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } op_state_t;

    // Low address bits for a burst beat.
    function automatic logic [1:0] beat_offset(input logic [1:0] base,
                                               input logic [1:0] beat,
                                               input logic       ilv);
        return ilv ? (base ^ beat) : (base + beat);
    endfunction

endpackage

// File: rtl/zt_burst_seq.sv
module zt_burst_seq
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              advance,
    input  logic              selected,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] addr,
    output op_state_t         op_state,
    output logic [ADDR_W-1:0] op_addr,
    output logic [LANES-1:0]  op_lane_n
);

    op_state_t         state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [1:0]        base_q, base_d;
    logic [1:0]        beat_q, beat_d;
    logic              ilv_q, ilv_d;
    logic [LANES-1:0]  lane_q, lane_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            base_q  <= '0;
            beat_q  <= '0;
            ilv_q   <= 1'b0;
            lane_q  <= '1;
        end else if (step) begin
            state_q <= state_d;
            addr_q  <= addr_d;
            base_q  <= base_d;
            beat_q  <= beat_d;
            ilv_q   <= ilv_d;
            lane_q  <= lane_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        base_d  = base_q;
        beat_d  = beat_q;
        ilv_d   = ilv_q;
        lane_d  = lane_wr_n;
        if (!advance) begin
            addr_d = addr;
            base_d = addr[1:0];
            beat_d = 2'd0;
            ilv_d  = interleave;
            if (!selected)  state_d = ST_IDLE;   // LOAD_DESEL
            else if (!wr_n) state_d = ST_WRITE;  // LOAD_WR
            else            state_d = ST_READ;   // LOAD_RD
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_READ, ST_WRITE: begin         // ADVANCE
                    beat_d = beat_q + 2'd1;
                    addr_d = {addr_q[ADDR_W-1:2],
                              beat_offset(base_q, beat_q + 2'd1, ilv_q)};
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign op_state  = state_q;
    assign op_addr   = addr_q;
    assign op_lane_n = lane_q;

endmodule

// File: rtl/zt_sram_core.sv
module zt_sram_core
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  op_state_t               op_state,
    input  logic [ADDR_W-1:0]       op_addr,
    input  logic [LANES-1:0]        op_lane_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe,
    output logic                    wr_pending
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    op_state_t         s2_state;
    logic [ADDR_W-1:0] s2_addr;
    logic [LANES-1:0]  s2_lane_n;
    logic [DATA_W-1:0] fwd_word;

    // Second pipeline stage: command whose data window is open now.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_state  <= ST_IDLE;
            s2_addr   <= '0;
            s2_lane_n <= '1;
        end else if (step) begin
            s2_state  <= op_state;
            s2_addr   <= op_addr;
            s2_lane_n <= op_lane_n;
        end
    end

    assign wr_pending = (s2_state == ST_WRITE);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];
        logic              hit;

        always_ff @(posedge clk) begin
            if (step && wr_pending && !s2_lane_n[g])
                bank[s2_addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign hit = wr_pending && (s2_addr == op_addr) && !s2_lane_n[g];
        assign fwd_word[g*LANE_W +: LANE_W] =
            hit ? wdata[g*LANE_W +: LANE_W] : bank[op_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata    <= '0;
            rdata_oe <= 1'b0;
        end else if (step) begin
            rdata_oe <= (op_state == ST_READ);
            if (op_state == ST_READ) rdata <= fwd_word;
        end
    end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_n,
    input  logic                    cs_a_n,
    input  logic                    cs_b,
    input  logic                    cs_c_n,
    input  logic                    advance,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    interleave,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe
);

    logic              step;
    logic              selected;
    op_state_t         op_state;
    logic [ADDR_W-1:0] op_addr;
    logic [LANES-1:0]  op_lane_n;
    logic              wr_pending;

    assign step     = !en_n;
    assign selected = !cs_a_n && cs_b && !cs_c_n;

    zt_burst_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) seq_i (
        .clk(clk), .rst_n(rst_n), .step(step), .advance(advance),
        .selected(selected), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
        .interleave(interleave), .addr(addr), .op_state(op_state),
        .op_addr(op_addr), .op_lane_n(op_lane_n)
    );

    zt_sram_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) core_i (
        .clk(clk), .rst_n(rst_n), .step(step), .op_state(op_state),
        .op_addr(op_addr), .op_lane_n(op_lane_n), .wdata(wdata),
        .rdata(rdata), .rdata_oe(rdata_oe), .wr_pending(wr_pending)
    );

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_n,
    input logic              cs_a_n,
    input logic              cs_b,
    input logic              cs_c_n,
    input logic              advance,
    input op_state_t         op_state,
    input logic [ADDR_W-1:0] op_addr,
    input logic              wr_pending,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_oe
);

    logic sel_now;
    assign sel_now = !cs_a_n && cs_b && !cs_c_n;

    assert_hold_outputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> ($stable(rdata) && $stable(rdata_oe)));

    assert_oe_off_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pending |-> !rdata_oe);

    assert_desel_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !advance && !sel_now) |=> (op_state == ST_IDLE));

    assert_burst_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && advance && op_state != ST_IDLE)
        |=> (op_addr[ADDR_W-1:2] == $past(op_addr[ADDR_W-1:2])));

    assert_read_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && op_state == ST_READ) |=> rdata_oe);

    assert_idle_adv_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && advance && op_state == ST_IDLE) |=> (op_state == ST_IDLE));

endmodule

bind zt_sram zt_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(LANES*LANE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .cs_a_n(cs_a_n), .cs_b(cs_b),
    .cs_c_n(cs_c_n), .advance(advance), .op_state(op_state),
    .op_addr(op_addr), .wr_pending(wr_pending), .rdata(rdata),
    .rdata_oe(rdata_oe)
);

// File: tb/zt_sram_tb_top.sv
module zt_sram_tb_top;

    localparam int AW = 6;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int DW = LN * LW;
    localparam int K_NONE = 0, K_RD = 1, K_WR = 2;
    localparam logic [2:0] SEL = 3'b010;  // {cs_a_n, cs_b, cs_c_n}

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n, en_n, cs_a_n, cs_b, cs_c_n, advance, wr_n, interleave;
    logic [LN-1:0] lane_wr_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata, rdata;
    logic          rdata_oe;

    zt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .cs_a_n(cs_a_n), .cs_b(cs_b),
        .cs_c_n(cs_c_n), .advance(advance), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
        .interleave(interleave), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rdata_oe(rdata_oe)
    );

    int    tests = 0;
    int    fails = 0;
    string tag   = "R1";

    logic [DW-1:0] model [1 << AW];
    int            b1_k = K_NONE, b2_k = K_NONE;
    logic [DW-1:0] b1_d = '0, b2_d = '0, b1_e = '0, b2_e = '0;
    int            bk = K_NONE;
    logic [1:0]    bbase = '0, bbeat = '0;
    logic          bilv = 1'b0;
    logic [AW-1:0] baddr = '0;

    function automatic logic [DW-1:0] rnd();
        logic [63:0] r;
        r = {$urandom, $urandom};
        return r[DW-1:0];
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [LN-1:0] bw);
        logic [DW-1:0] m;
        m = old_w;
        for (int i = 0; i < LN; i++)
            if (!bw[i]) m[i*LW +: LW] = new_w[i*LW +: LW];
        return m;
    endfunction

    function automatic logic [1:0] nxt_low(input logic [1:0] b, input logic [1:0] k,
                                           input logic il);
        logic [1:0] v;
        if (il) v = b ^ k;
        else    v = b + k;
        return v;
    endfunction

    task automatic check(input string t, input logic [DW:0] act, input logic [DW:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    task automatic cyc(input logic en, input logic adv, input logic [2:0] cs,
                       input logic wn, input logic [LN-1:0] bw, input logic [AW-1:0] a,
                       input logic ilv, input logic [DW-1:0] d);
        int            k;
        logic [DW-1:0] e;
        @(negedge clk);
        if (b2_k == K_RD) check(tag, {rdata_oe, rdata}, {1'b1, b2_e});
        else if (b2_k == K_WR) check("R6", {rdata_oe, {DW{1'b0}}}, '0);
        else check(tag, {rdata_oe, {DW{1'b0}}}, '0);
        wdata = (b2_k == K_WR) ? b2_d : rnd();
        en_n = !en; cs_a_n = cs[2]; cs_b = cs[1]; cs_c_n = cs[0];
        advance = adv; wr_n = wn; lane_wr_n = bw; addr = a; interleave = ilv;
        if (en) begin
            if (!adv) begin
                k = (cs == SEL) ? (wn ? K_RD : K_WR) : K_NONE;
                bk = k; bbase = a[1:0]; bbeat = 2'd0; bilv = ilv; baddr = a;
            end else begin
                k = bk;
                if (bk != K_NONE) begin
                    bbeat = bbeat + 2'd1;
                    baddr = {baddr[AW-1:2], nxt_low(bbase, bbeat, bilv)};
                end
            end
            if (k == K_WR) model[baddr] = merge(model[baddr], d, bw);
            e = model[baddr];
            @(posedge clk);
            b2_k = b1_k; b2_d = b1_d; b2_e = b1_e;
            b1_k = k;    b1_d = d;    b1_e = e;
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [LN-1:0] bw, input logic [DW-1:0] d);
        cyc(1'b1, 1'b0, SEL, 1'b0, bw, a, 1'b0, d);
    endtask
    task automatic rd(input logic [AW-1:0] a);
        cyc(1'b1, 1'b0, SEL, 1'b1, '1, a, 1'b0, rnd());
    endtask
    task automatic nop();
        cyc(1'b1, 1'b0, 3'b000, 1'b0, '0, AW'($urandom), 1'b0, rnd());
    endtask
    task automatic flush();
        nop(); nop();
    endtask
    task automatic hold();
        cyc(1'b0, 1'($urandom), 3'($urandom), 1'($urandom), LN'($urandom),
            AW'($urandom), 1'($urandom), rnd());
    endtask
    task automatic burst(input logic wn, input logic [AW-1:0] a, input logic il, input int beats);
        cyc(1'b1, 1'b0, SEL, wn, LN'($urandom), a, il, rnd());
        for (int i = 1; i < beats; i++)
            cyc(1'b1, 1'b1, 3'($urandom), !wn, LN'($urandom), AW'($urandom), !il, rnd());
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL %s watchdog: actual hung expected finished", tag);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; en_n = 1'b1; cs_a_n = 1'b1; cs_b = 1'b0; cs_c_n = 1'b1;
        advance = 1'b0; wr_n = 1'b1; lane_wr_n = '1; interleave = 1'b0;
        addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        check("R1", {rdata_oe, rdata}, '0);
        rst_n = 1'b1;

        tag = "R3";
        for (int i = 0; i < (1 << AW); i++) wr(AW'(i), '0, rnd());
        flush();
        tag = "R2";
        for (int i = 0; i < (1 << AW); i++) rd(AW'(i));
        flush();

        tag = "R3";
        wr(6'd5, 4'b1010, rnd()); nop(); nop(); rd(6'd5);
        wr(6'd6, 4'b0111, rnd()); nop(); nop(); rd(6'd6);
        flush();

        tag = "R10";
        wr(6'd9, 4'b0011, rnd()); rd(6'd9);
        wr(6'd9, 4'b1100, rnd()); nop(); rd(6'd9);
        wr(6'd10, 4'b0000, rnd()); rd(6'd11); rd(6'd10);
        wr(6'd12, 4'b0110, rnd()); rd(6'd12); rd(6'd12);
        flush();

        tag = "R5";
        for (int i = 0; i < 8; i++) begin
            wr(AW'(32 + i), LN'($urandom), rnd());
            rd(AW'(32 + i));
        end
        for (int i = 0; i < 6; i++) begin
            rd(AW'(40 + i));
            wr(AW'(40 + i), 4'b0000, rnd());
        end
        flush();

        tag = "R7";
        wr(6'd20, 4'b0000, rnd()); hold(); hold(); rd(6'd20); hold(); hold();
        nop(); hold(); rd(6'd21); wr(6'd21, 4'b0101, rnd()); hold(); rd(6'd21);
        flush();

        tag = "R4";
        cyc(1'b1, 1'b0, 3'b110, 1'b0, '0, 6'd30, 1'b0, rnd());
        cyc(1'b1, 1'b0, 3'b000, 1'b0, '0, 6'd30, 1'b0, rnd());
        cyc(1'b1, 1'b0, 3'b011, 1'b0, '0, 6'd30, 1'b0, rnd());
        cyc(1'b1, 1'b0, 3'b011, 1'b1, '1, 6'd30, 1'b0, rnd());
        rd(6'd30);
        flush();

        tag = "R8";
        burst(1'b0, 6'd14, 1'b0, 4);
        burst(1'b1, 6'd13, 1'b0, 5);
        burst(1'b1, 6'd15, 1'b0, 4);
        flush();

        tag = "R9";
        burst(1'b0, 6'd23, 1'b1, 4);
        burst(1'b1, 6'd22, 1'b1, 5);
        burst(1'b1, 6'd21, 1'b1, 4);
        flush();

        tag = "R11";
        cyc(1'b1, 1'b0, 3'b000, 1'b0, '0, 6'd48, 1'b0, rnd());
        cyc(1'b1, 1'b1, SEL, 1'b0, '0, 6'd48, 1'b0, rnd());
        cyc(1'b1, 1'b1, SEL, 1'b0, '0, 6'd49, 1'b0, rnd());
        rd(6'd48); rd(6'd49);
        burst(1'b1, 6'd50, 1'b0, 4);
        flush();

        tag = "R2";
        for (int n = 0; n < 3000; n++) begin
            logic e_b, a_b;
            logic [2:0] c;
            e_b = ($urandom % 10) != 0;
            a_b = ($urandom % 4) == 0;
            c = (($urandom % 8) == 0) ? 3'($urandom) : SEL;
            cyc(e_b, a_b, c, 1'($urandom), LN'($urandom), AW'($urandom),
                1'($urandom), rnd());
        end
        flush();

        tag = "R3";
        for (int i = 0; i < (1 << AW); i++) rd(AW'(i));
        flush();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule